// File: doc/BRIEF.md
# Packed Signed 16-bit Multiplier with Pairwise Accumulate

This block multiplies two 64-bit operands lane by lane, where each operand holds four signed 16-bit values. Each lane pair produces a full 32-bit two's-complement product. An operation select then picks what the 64-bit result holds:

- the lower half of every product, or
- the upper half of every product, or
- two 32-bit sums, each formed from a pair of neighbouring products. This form serves dot-product kernels that keep a running total elsewhere.

The result is captured in a single output register. A valid flag travels alongside the data, so the result appears exactly one clock after the operands are presented with their valid flag. When no valid operands arrive, the output register keeps its last value. The caller can therefore read a result at leisure.

Top module: `simd_mul16`

## Requirements
- R1: While `rst_n` is low, `out_valid` is 0 and `result` is all zeros.
- R2: `out_valid` in any cycle equals `in_valid` sampled at the preceding rising clock edge.
- R3: With `op_sel` = 2'b00, lane i of `result` (bits 16i+15..16i) is the low 16 bits of the signed product of lane i of `opnd_a` and lane i of `opnd_b`.
- R4: With `op_sel` = 2'b01, lane i of `result` is the high 16 bits (product bits 31..16) of the signed lane-i product.
- R5: With `op_sel` = 2'b10, `result[31:0]` is product0 + product1 and `result[63:32]` is product2 + product3, where productN is the 32-bit signed product of lane N.
- R6: Lanes are signed two's complement, so 0xFFFF * 0x0001 gives low half 0xFFFF and high half 0xFFFF, and 0xFFFF * 0xFFFF gives low half 0x0001 and high half 0x0000.
- R7: The 32-bit pair sum in R5 wraps modulo 2^32. When all eight lanes are 0x8000, each half of `result` reads 0x80000000.
- R8: With `op_sel` = 2'b11, the captured result is all zeros.
- R9: A rising edge with `in_valid` low leaves `result` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low reset |
| in_valid | input | 1 | Operands and select are valid this cycle |
| op_sel | input | 2 | 00 low halves, 01 high halves, 10 pairwise sums, 11 zero |
| opnd_a | input | 64 | First operand, four signed 16-bit lanes |
| opnd_b | input | 64 | Second operand, four signed 16-bit lanes |
| out_valid | output | 1 | Result register was loaded at the last edge |
| result | output | 64 | Registered result |

## Verification
Every result of this block is due one rising edge after its operands. The bench therefore drives operands and select at a falling edge, lets the next rising edge capture them, and compares `result` and `out_valid` at the falling edge that follows, against a behavioural model updated at that same rising edge. Cycles with `in_valid` low are compared against the value the model captured last, which checks the hold behaviour in the very cycle it could break. The reset value is compared at falling edges while reset is still asserted.

// File: rtl/simd_mul_pkg.sv
package simd_mul_pkg;
  localparam int LANE_W_DEF = 16;
  localparam int LANES_DEF  = 4;

  typedef enum logic [1:0] {
    OP_MUL_LO = 2'b00,
    OP_MUL_HI = 2'b01,
    OP_MADD   = 2'b10,
    OP_ZERO   = 2'b11
  } mul_op_e;
endpackage

// File: rtl/simd_smul_lane.sv
module simd_smul_lane #(
  parameter int W = 16
) (
  input  logic [W-1:0]   a,
  input  logic [W-1:0]   b,
  output logic [2*W-1:0] prod
);
  localparam int PW = 2 * W;

  function automatic logic [PW-1:0] f_sext(input logic [W-1:0] v);
    return {{W{v[W-1]}}, v};
  endfunction

  function automatic logic [PW-1:0] f_smul(input logic [W-1:0] x, input logic [W-1:0] y);
    logic [PW-1:0] ex;
    logic [PW-1:0] ey;
    ex = f_sext(x);
    ey = f_sext(y);
    return ex * ey;
  endfunction

  assign prod = f_smul(a, b);
endmodule

// File: rtl/simd_lane_combine.sv
module simd_lane_combine
  import simd_mul_pkg::*;
#(
  parameter int LANES = 4,
  parameter int W     = 16
) (
  input  logic [1:0]           op,
  input  logic [LANES*2*W-1:0] prods,
  output logic [LANES*W-1:0]   res
);
  localparam int PW    = 2 * W;
  localparam int PAIRS = LANES / 2;
  localparam int DW    = LANES * W;

  function automatic logic [PW-1:0] f_pair_add(input logic [PW-1:0] p0, input logic [PW-1:0] p1);
    return p0 + p1;
  endfunction

  logic [DW-1:0] lo_v;
  logic [DW-1:0] hi_v;
  logic [DW-1:0] madd_v;

  for (genvar i = 0; i < LANES; i++) begin : g_half
    assign lo_v[i*W +: W] = prods[i*PW +: W];
    assign hi_v[i*W +: W] = prods[i*PW + W +: W];
  end

  for (genvar j = 0; j < PAIRS; j++) begin : g_pair
    assign madd_v[j*PW +: PW] = f_pair_add(prods[2*j*PW +: PW], prods[(2*j+1)*PW +: PW]);
  end

  always_comb begin
    case (mul_op_e'(op))
      OP_MUL_LO: res = lo_v;
      OP_MUL_HI: res = hi_v;
      OP_MADD:   res = madd_v;
      default:   res = '0;
    endcase
  end
endmodule

// File: rtl/simd_out_stage.sv
module simd_out_stage #(
  parameter int DW = 64
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [DW-1:0] d,
  output logic [DW-1:0] q,
  output logic          vld
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q   <= '0;
      vld <= 1'b0;
    end else begin
      vld <= load;
      if (load) q <= d;
    end
  end
endmodule

// File: rtl/simd_mul16.sv
module simd_mul16
  import simd_mul_pkg::*;
#(
  parameter int LANES  = LANES_DEF,
  parameter int LANE_W = LANE_W_DEF
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      in_valid,
  input  logic [1:0]                op_sel,
  input  logic [LANES*LANE_W-1:0]   opnd_a,
  input  logic [LANES*LANE_W-1:0]   opnd_b,
  output logic                      out_valid,
  output logic [LANES*LANE_W-1:0]   result
);
  localparam int DW = LANES * LANE_W;
  localparam int PW = 2 * LANE_W;

  logic [LANES*PW-1:0] lane_prod;
  logic [DW-1:0]       nxt_result;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    simd_smul_lane #(.W(LANE_W)) u_mul (
      .a    (opnd_a[i*LANE_W +: LANE_W]),
      .b    (opnd_b[i*LANE_W +: LANE_W]),
      .prod (lane_prod[i*PW +: PW])
    );
  end

  simd_lane_combine #(.LANES(LANES), .W(LANE_W)) u_comb (
    .op    (op_sel),
    .prods (lane_prod),
    .res   (nxt_result)
  );

  simd_out_stage #(.DW(DW)) u_out (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (in_valid),
    .d     (nxt_result),
    .q     (result),
    .vld   (out_valid)
  );
endmodule

// File: rtl/simd_mul16_chk.sv
module simd_mul16_chk #(
  parameter int LANES  = 4,
  parameter int LANE_W = 16
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    in_valid,
  input logic [1:0]              op_sel,
  input logic [LANES*2*LANE_W-1:0] lane_prod,
  input logic                    out_valid,
  input logic [LANES*LANE_W-1:0] result
);
  localparam int PW = 2 * LANE_W;

  AST_VALID_SET: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid); // R2
  AST_VALID_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid); // R2
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(result)); // R9
  AST_ZERO_OP: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op_sel == 2'b11) |=> (result == '0)); // R8

  for (genvar i = 0; i < LANES; i++) begin : g_lane_chk
    AST_LOW_HALF: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && op_sel == 2'b00) |=> (result[i*LANE_W +: LANE_W] == $past(lane_prod[i*PW +: LANE_W]))); // R3
    AST_HIGH_HALF: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && op_sel == 2'b01) |=> (result[i*LANE_W +: LANE_W] == $past(lane_prod[i*PW + LANE_W +: LANE_W]))); // R4
  end

  for (genvar j = 0; j < LANES/2; j++) begin : g_pair_chk
    AST_PAIR_SUM: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && op_sel == 2'b10) |=> (result[j*PW +: PW] ==
        $past(lane_prod[2*j*PW +: PW] + lane_prod[(2*j+1)*PW +: PW]))); // R5
  end

  always_comb begin
    if (!rst_n) AST_RESET_STATE: assert (out_valid == 1'b0); // R1
  end
endmodule

bind simd_mul16 simd_mul16_chk #(.LANES(LANES), .LANE_W(LANE_W)) u_chk (.*);

// File: tb/simd_mul16_bench.sv
module simd_mul16_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [1:0]  op_sel = 2'b00;
  logic [63:0] opnd_a = '0;
  logic [63:0] opnd_b = '0;
  logic        out_valid;
  logic [63:0] result;

  int n_checks = 0;
  int n_errors = 0;
  int cycles = 0;
  logic        exp_valid = 1'b0;
  logic [63:0] exp_res = '0;

  always #10 clk = ~clk;

  simd_mul16 u_simd_mul16 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_sel(op_sel),
    .opnd_a(opnd_a), .opnd_b(opnd_b), .out_valid(out_valid), .result(result)
  );

  function automatic logic [63:0] ref_model(input logic [1:0] op, input logic [63:0] a, input logic [63:0] b);
    longint p[4];
    logic [63:0] r;
    for (int i = 0; i < 4; i++) begin
      int sa;
      int sb;
      sa = int'($signed(a[16*i +: 16]));
      sb = int'($signed(b[16*i +: 16]));
      p[i] = longint'(sa) * longint'(sb);
    end
    r = '0;
    if (op == 2'd0) for (int i = 0; i < 4; i++) r[16*i +: 16] = p[i][15:0];
    else if (op == 2'd1) for (int i = 0; i < 4; i++) r[16*i +: 16] = p[i][31:16];
    else if (op == 2'd2) begin
      longint s0;
      longint s1;
      s0 = p[0] + p[1];
      s1 = p[2] + p[3];
      r = {s1[31:0], s0[31:0]};
    end
    return r;
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(input logic v, input logic [1:0] op, input logic [63:0] a,
                      input logic [63:0] b, input string req);
    in_valid = v; op_sel = op; opnd_a = a; opnd_b = b;
    @(posedge clk);
    exp_valid = v;
    if (v) exp_res = ref_model(op, a, b);
    @(negedge clk);
    check("R2 out_valid", {63'd0, out_valid}, {63'd0, exp_valid});
    check(req, result, exp_res);
  endtask

  function automatic string op_tag(input logic v, input logic [1:0] op);
    if (!v) return "R9 hold";
    case (op)
      2'd0: return "R3 low";
      2'd1: return "R4 high";
      2'd2: return "R5 madd";
      default: return "R8 zero";
    endcase
  endfunction

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      n_errors++;
      $display("FAIL watchdog actual=%0d expected<=20000", cycles);
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end

  initial begin
    in_valid = 1'b1; op_sel = 2'd1; opnd_a = '1; opnd_b = 64'h0001_0001_0001_0001;
    repeat (3) begin
      @(negedge clk);
      check("R1 reset valid", {63'd0, out_valid}, 64'd0);
      check("R1 reset result", result, 64'd0);
    end
    in_valid = 1'b0;
    rst_n = 1'b1;
    @(negedge clk);
    // lanes (high..low): -32768,1000,-2,3 times 2,300,7,5
    step(1'b1, 2'd0, 64'h8000_03E8_FFFE_0003, 64'h0002_012C_0007_0005, "R3 low directed");
    step(1'b1, 2'd1, 64'h8000_03E8_FFFE_0003, 64'h0002_012C_0007_0005, "R4 high directed");
    step(1'b1, 2'd0, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0001_0001_0001_0001, "R6 signed low -1*1");
    check("R6 value -1*1 low", result, 64'hFFFF_FFFF_FFFF_FFFF);
    step(1'b1, 2'd1, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0001_0001_0001_0001, "R6 signed high -1*1");
    check("R6 value -1*1 high", result, 64'hFFFF_FFFF_FFFF_FFFF);
    step(1'b1, 2'd0, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, "R6 signed low -1*-1");
    check("R6 value -1*-1 low", result, 64'h0001_0001_0001_0001);
    step(1'b1, 2'd1, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, "R6 signed high -1*-1");
    check("R6 value -1*-1 high", result, 64'h0000_0000_0000_0000);
    step(1'b1, 2'd2, 64'h0004_0003_0002_0001, 64'h0008_0007_0006_0005, "R5 madd directed");
    check("R5 value 1*5+2*6, 3*7+4*8", result, 64'h0000_0035_0000_0011);
    step(1'b1, 2'd2, 64'h8000_8000_8000_8000, 64'h8000_8000_8000_8000, "R7 wrap");
    check("R7 value", result, 64'h8000_0000_8000_0000);
    step(1'b0, 2'd0, 64'h1234_5678_9ABC_DEF0, 64'h1111_2222_3333_4444, "R9 hold after madd");
    check("R9 value kept", result, 64'h8000_0000_8000_0000);
    step(1'b1, 2'd3, 64'h1234_5678_9ABC_DEF0, 64'h1111_2222_3333_4444, "R8 zero op");
    check("R8 value", result, 64'd0);
    step(1'b1, 2'd1, 64'h7FFF_8000_7FFF_8000, 64'h7FFF_7FFF_8000_8000, "R4 extremes");
    step(1'b0, 2'd2, 64'h7FFF_8000_7FFF_8000, 64'h7FFF_7FFF_8000_8000, "R9 hold after high");
    for (int k = 0; k < 400; k++) begin
      logic v;
      logic [1:0] op;
      v  = ($urandom % 4) != 0;
      op = 2'($urandom % 4);
      step(v, op, {$urandom, $urandom}, {$urandom, $urandom}, op_tag(v, op));
    end
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end
endmodule